// File: doc/BRIEF.md
# Paced ADC Sample Trigger Timer

This block paces a free-running analog-to-digital converter. It picks one of three tick-enable streams, divides the chosen stream by 1, 2 or 3 in a prescaler, and feeds the result to a countdown divider. The divider's period has an integer part and a fractional part, in prescaled ticks. Each time the countdown expires, the block issues a one-cycle sample strobe and reloads the countdown. This repeats until the requested number of samples has been triggered.

Each conversion result that returns on the data-valid input is passed to a buffer write port, with an index that starts at zero for every capture. A one-cycle done pulse and a sticky done bit mark the end of a capture. A start strobe loads the configuration and begins a new capture. Changes to the divider word and the prescaler during a capture are picked up at the next reload.

Top module: `paced_sample_timer`

## Requirements
- R1: The divider word carries the integer period in bits 23:8, in prescaled ticks. Consecutive sample strobes are integer × prescale × source-spacing clock cycles apart. An integer value of 0 behaves as 1.
- R2: The prescaler field selects the divide ratio: 1, 2 and 3 divide by 1, 2 and 3, and 0 divides by 1.
- R3: `src_sel_i` values 0, 1 and 2 select bit 0, 1 and 2 of `tick_en_i` as the tick source. Value 3 selects bit 0.
- R4: Bits 7:0 of the divider word are a fraction. An 8-bit accumulator starts at 0 on start, and the fraction is added to it at each reload. A carry out of the accumulator lengthens the next period by one prescaled tick.
- R5: A capture issues exactly `count_i` sample strobes and then no more. A count of 0 behaves as 1.
- R6: Each `adc_valid_i` pulse that arrives while a triggered sample has not yet been written produces one `wr_en_o` pulse, carrying `adc_data_i` and an index that runs 0, 1, 2, … within the capture. A valid pulse with no pending sample, including before any start and after done, is ignored.
- R7: `done_pulse_o` is high for exactly one cycle, in the cycle after the last write strobe. `done_o` rises with it and stays high until the next start.
- R8: A start clears `done_o` in the cycle after it is sampled. A divider word changed during a capture first shapes the period that follows the next reload.
- R9: With source spacing 1 and prescale 1, the first sample strobe is visible N+1 cycles after the cycle in which start is high, where N is the effective integer period.
- R10: After reset, `sample_o`, `wr_en_o`, `done_pulse_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | NUM_SRC (3) | Tick-enable streams at different rates |
| src_sel_i | input | 2 | Tick source select |
| div_word_i | input | 24 | Integer period [23:8], fraction [7:0] |
| presc_i | input | 2 | Prescaler ratio field |
| count_i | input | CNT_W | Number of samples per capture |
| start_i | input | 1 | Start a capture (one-cycle strobe) |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_data_i | input | DATA_W | Conversion result |
| sample_o | output | 1 | Sample-start strobe |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_idx_o | output | CNT_W | Buffer write index |
| wr_data_o | output | DATA_W | Buffer write data |
| done_pulse_o | output | 1 | One-cycle end-of-capture pulse |
| done_o | output | 1 | Sticky end-of-capture flag |

## Verification
The assertions check the following on every cycle. The countdown never holds zero. The prescaler phase stays inside its range. Triggers never exceed the latched count. Writes never overtake triggers, and the write index stays below the count. The done pulse follows a write strobe and leaves the block idle.

Only the bench's sweeps can show the actual strobe spacing for each source, prescale and integer value. They also show the carry pattern that the fraction produces, the exact delay of the first strobe, the data and index order in the buffer, and the point at which a mid-capture divider change takes effect.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int INT_W   = 16;
    localparam int FRAC_W  = 8;
    localparam int DIV_W   = INT_W + FRAC_W;
    localparam int NUM_SRC = 3;
    localparam int PRE_W   = 2;

    function automatic logic [PRE_W-1:0] presc_last(input logic [PRE_W-1:0] ratio);
        return (ratio == '0) ? '0 : ratio - 1'b1;
    endfunction
endpackage

// File: rtl/pst_tick_prescaler.sv
module pst_tick_prescaler
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] ratio_i,
    output logic             ptick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic       wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.phase >= presc_last(ratio_i));
        ptick_o = tick_i && wrap && !clear_i;
        if (clear_i) begin
            s_d.phase = '0;
        end else if (tick_i) begin
            s_d.phase = wrap ? '0 : s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase <= 2'd2); // R2
endmodule

// File: rtl/pst_period_gen.sv
module pst_period_gen
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             ptick_i,
    input  logic [DIV_W-1:0] div_word_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             fire_o,
    output logic [PRE_W-1:0] presc_o
);
    typedef struct packed {
        logic [INT_W:0]    cnt;
        logic [FRAC_W-1:0] acc;
        logic [PRE_W-1:0]  presc;
    } pg_state_t;

    pg_state_t         s_d, s_q;
    logic [INT_W-1:0]  int_eff;
    logic [FRAC_W:0]   acc_sum;

    always_comb begin
        s_d     = s_q;
        int_eff = div_word_i[DIV_W-1:FRAC_W];
        if (int_eff == '0) int_eff = 1;
        acc_sum = {1'b0, s_q.acc} + {1'b0, div_word_i[FRAC_W-1:0]};
        fire_o  = run_i && ptick_i && (s_q.cnt == 1);
        if (load_i) begin
            s_d.cnt   = {1'b0, int_eff};
            s_d.acc   = '0;
            s_d.presc = presc_i;
        end else if (fire_o) begin
            s_d.cnt   = {1'b0, int_eff} + {{INT_W{1'b0}}, acc_sum[FRAC_W]};
            s_d.acc   = acc_sum[FRAC_W-1:0];
            s_d.presc = presc_i;
        end else if (run_i && ptick_i) begin
            s_d.cnt   = s_q.cnt - 1'b1;
        end
    end

    assign presc_o = s_q.presc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= 1;
            s_q.acc   <= '0;
            s_q.presc <= 2'd1;
        end else begin
            s_q <= s_d;
        end
    end

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt != '0); // R1
endmodule

// File: rtl/pst_capture_ctrl.sv
module pst_capture_ctrl #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fire_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              adc_valid_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              run_o,
    output logic              sample_o,
    output logic              wr_en_o,
    output logic [CNT_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_pulse_o,
    output logic              done_o
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  trig;
        logic [CNT_W-1:0]  wr;
        logic [CNT_W-1:0]  limit;
        logic              sample;
        logic              wr_en;
        logic [CNT_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
        logic              last;
        logic              done_pulse;
        logic              done;
    } cap_state_t;

    cap_state_t       s_d, s_q;
    logic             accept;
    logic [CNT_W-1:0] cnt_eff;

    always_comb begin
        s_d            = s_q;
        s_d.sample     = 1'b0;
        s_d.wr_en      = 1'b0;
        s_d.last       = 1'b0;
        s_d.done_pulse = 1'b0;
        cnt_eff = (count_i == '0) ? 1 : count_i;
        run_o   = s_q.busy && (s_q.trig < s_q.limit);
        accept  = s_q.busy && adc_valid_i && (s_q.wr < s_q.trig);
        if (start_i) begin
            s_d.busy  = 1'b1;
            s_d.trig  = '0;
            s_d.wr    = '0;
            s_d.limit = cnt_eff;
            s_d.done  = 1'b0;
        end else begin
            if (fire_i) begin
                s_d.trig   = s_q.trig + 1'b1;
                s_d.sample = 1'b1;
            end
            if (accept) begin
                s_d.wr_en   = 1'b1;
                s_d.wr_idx  = s_q.wr;
                s_d.wr_data = adc_data_i;
                s_d.wr      = s_q.wr + 1'b1;
                s_d.last    = (s_q.wr == s_q.limit - 1'b1);
            end
            if (s_q.last) begin
                s_d.done_pulse = 1'b1;
                s_d.done       = 1'b1;
                s_d.busy       = 1'b0;
            end
        end
    end

    assign sample_o     = s_q.sample;
    assign wr_en_o      = s_q.wr_en;
    assign wr_idx_o     = s_q.wr_idx;
    assign wr_data_o    = s_q.wr_data;
    assign done_pulse_o = s_q.done_pulse;
    assign done_o       = s_q.done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.limit <= 1;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TRIG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig <= s_q.limit); // R5
    AST_WR_BEHIND_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr <= s_q.trig); // R6
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_en |-> (s_q.wr_idx < s_q.limit)); // R6
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done_pulse |-> $past(s_q.wr_en)); // R7
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done_pulse |-> (!s_q.busy && s_q.done)); // R7
endmodule

// File: rtl/paced_sample_timer.sv
module paced_sample_timer
    import pst_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_en_i,
    input  logic [1:0]         src_sel_i,
    input  logic [DIV_W-1:0]   div_word_i,
    input  logic [PRE_W-1:0]   presc_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               start_i,
    input  logic               adc_valid_i,
    input  logic [DATA_W-1:0]  adc_data_i,
    output logic               sample_o,
    output logic               wr_en_o,
    output logic [CNT_W-1:0]   wr_idx_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               done_pulse_o,
    output logic               done_o
);
    logic             tick_sel;
    logic             ptick;
    logic             fire;
    logic             run;
    logic [PRE_W-1:0] presc_act;

    always_comb begin
        tick_sel = tick_en_i[0];
        for (int i = 1; i < NUM_SRC; i++) begin
            if (int'(src_sel_i) == i) tick_sel = tick_en_i[i];
        end
    end

    pst_tick_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .tick_i  (tick_sel),
        .ratio_i (presc_act),
        .ptick_o (ptick)
    );

    pst_period_gen u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .run_i      (run),
        .ptick_i    (ptick),
        .div_word_i (div_word_i),
        .presc_i    (presc_i),
        .fire_o     (fire),
        .presc_o    (presc_act)
    );

    pst_capture_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fire_i       (fire),
        .count_i      (count_i),
        .adc_valid_i  (adc_valid_i),
        .adc_data_i   (adc_data_i),
        .run_o        (run),
        .sample_o     (sample_o),
        .wr_en_o      (wr_en_o),
        .wr_idx_o     (wr_idx_o),
        .wr_data_o    (wr_data_o),
        .done_pulse_o (done_pulse_o),
        .done_o       (done_o)
    );
endmodule

// File: tb/paced_sample_timer_tb_top.sv
module paced_sample_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        tick_en_i = '0;
    logic [1:0]        src_sel_i = '0;
    logic [23:0]       div_word_i = '0;
    logic [1:0]        presc_i = '0;
    logic [CNT_W-1:0]  count_i = '0;
    logic              start_i = 1'b0;
    logic              adc_valid_i = 1'b0;
    logic [DATA_W-1:0] adc_data_i = '0;
    logic              sample_o, wr_en_o, done_pulse_o, done_o;
    logic [CNT_W-1:0]  wr_idx_o;
    logic [DATA_W-1:0] wr_data_o;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int t_start = 0;
    int n_samp = 0, n_wr = 0, n_done = 0, wr_any = 0, conv = 0;
    int ts[64];
    int widx[64];
    int wdat[64];
    logic [1:0] pend = '0;
    bit force_valid = 1'b0;

    paced_sample_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .src_sel_i(src_sel_i),
        .div_word_i(div_word_i), .presc_i(presc_i), .count_i(count_i),
        .start_i(start_i), .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i),
        .sample_o(sample_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .done_pulse_o(done_pulse_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Tick sources, converter model and output recorder, all at the falling edge.
    always @(negedge clk) begin
        tick_en_i[0] = 1'b1;
        tick_en_i[1] = (cyc % 2 == 0);
        tick_en_i[2] = (cyc % 4 == 0);
        if (wr_en_o) wr_any++;
        if (start_i) begin
            n_samp = 0; n_wr = 0; n_done = 0; conv = 0; pend = '0;
            t_start = cyc;
        end else begin
            if (sample_o && n_samp < 64) begin ts[n_samp] = cyc; n_samp++; end
            if (wr_en_o && n_wr < 64) begin
                widx[n_wr] = int'(wr_idx_o); wdat[n_wr] = int'(wr_data_o); n_wr++;
            end
            if (done_pulse_o) n_done++;
        end
        pend = {pend[0], sample_o && !start_i};
        adc_valid_i = pend[1] || force_valid;
        adc_data_i  = force_valid ? 8'h55 : DATA_W'(conv * 7 + 3);
        if (pend[1]) conv++;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done_o; i++) step();
    endtask

    task automatic run_cap(input int src, input int presc, input int ival, input int frac,
                           input int cnt, input string tag, input bit chk_first);
        int s, p, n, ce, acc, sum, per;
        s  = (src == 1) ? 2 : (src == 2) ? 4 : 1;
        p  = (presc == 0) ? 1 : presc;
        n  = (ival == 0) ? 1 : ival;
        ce = (cnt == 0) ? 1 : cnt;
        src_sel_i  = 2'(src);
        presc_i    = 2'(presc);
        div_word_i = 24'((ival << 8) | frac);
        count_i    = CNT_W'(cnt);
        pulse_start();
        chk(done_o == 1'b0, "R8", "done cleared by start", int'(done_o), 0);
        wait_done(20000);
        step(); step();
        chk(n_samp == ce, "R5", "sample count", n_samp, ce);
        if (chk_first && n_samp > 0)
            chk(ts[0] - t_start == n + 1, "R9", "first strobe delay", ts[0] - t_start, n + 1);
        acc = 0;
        for (int k = 1; k < n_samp; k++) begin
            sum = acc + frac;
            acc = sum % 256;
            per = (n + sum / 256) * p * s;
            chk(ts[k] - ts[k-1] == per, tag, "strobe spacing", ts[k] - ts[k-1], per);
        end
        chk(n_wr == ce, "R6", "write count", n_wr, ce);
        for (int k = 0; k < n_wr; k++) begin
            chk(widx[k] == k, "R6", "write index", widx[k], k);
            chk(wdat[k] == ((k * 7 + 3) % 256), "R6", "write data", wdat[k], (k * 7 + 3) % 256);
        end
        chk(n_done == 1, "R7", "done pulse count", n_done, 1);
        repeat (5) step();
        chk(done_o == 1'b1, "R7", "done sticky", int'(done_o), 1);
        chk(n_samp == ce, "R5", "no strobes after done", n_samp, ce);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        int w0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk(sample_o == 0, "R10", "sample after reset", int'(sample_o), 0);
        chk(wr_en_o == 0, "R10", "write after reset", int'(wr_en_o), 0);
        chk(done_o == 0, "R10", "done after reset", int'(done_o), 0);
        chk(done_pulse_o == 0, "R10", "done pulse after reset", int'(done_pulse_o), 0);
        // R6: valid with nothing pending is ignored
        w0 = wr_any;
        @(negedge clk); force_valid = 1'b1; @(negedge clk); force_valid = 1'b0;
        step(); step();
        chk(wr_any == w0, "R6", "stray valid before start", wr_any - w0, 0);

        // R1/R2/R3 sweep over source, prescale and integer period
        for (int src = 0; src < 4; src++)
            for (int pr = 0; pr < 4; pr++)
                for (int iv = 0; iv < 3; iv++)
                    run_cap(src, pr, (iv == 2) ? 3 : iv, 0, 3,
                            (src != 0) ? "R3" : (pr != 1) ? "R2" : "R1",
                            (src == 0 || src == 3) && pr < 2);

        // R4: fractional accumulation
        run_cap(0, 1, 2, 8'h01, 9, "R4", 1'b1);
        run_cap(0, 1, 2, 8'h40, 9, "R4", 1'b1);
        run_cap(0, 1, 2, 8'h80, 9, "R4", 1'b1);
        run_cap(1, 2, 2, 8'hC0, 9, "R4", 1'b0);
        run_cap(0, 3, 1, 8'hFF, 9, "R4", 1'b0);

        // R1: large periods
        run_cap(0, 1, 96, 0, 3, "R1", 1'b1);
        run_cap(2, 3, 300, 0, 2, "R1", 1'b0);
        // R5: count of zero behaves as one
        run_cap(0, 1, 4, 0, 0, "R5", 1'b1);

        // R6: valid after done is ignored
        w0 = wr_any;
        @(negedge clk); force_valid = 1'b1; @(negedge clk); force_valid = 1'b0;
        step(); step();
        chk(wr_any == w0, "R6", "stray valid after done", wr_any - w0, 0);

        // R8: divider change mid-capture applies after the next reload
        src_sel_i = 2'd0; presc_i = 2'd1; div_word_i = 24'(5 << 8); count_i = CNT_W'(3);
        pulse_start();
        for (int i = 0; i < 100 && n_samp < 1; i++) step();
        div_word_i = 24'(3 << 8);
        wait_done(1000);
        step(); step();
        chk(n_samp == 3, "R8", "samples with change", n_samp, 3);
        chk(ts[1] - ts[0] == 5, "R8", "period before reload", ts[1] - ts[0], 5);
        chk(ts[2] - ts[1] == 3, "R8", "period after reload", ts[2] - ts[1], 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule